// File: doc/BRIEF.md
# Periodic Compare-Match Timer Channel

This block is one channel of a 16-bit up-counting timer, reached through a small register file on a simple single-cycle bus. Software picks a count clock by dividing the system clock by 1, 4, 16 or 64. It loads a compare value and the counter's start value, and then sets the channel's run bit. With compare-match clearing selected, the counter steps from zero up to one below the compare value and then wraps to zero. This gives a fixed period of "compare value" count ticks. Each such match sets a status flag, and that flag drives a level interrupt when it is enabled.

The run bit lives in a start/stop register that several channels share. This channel acts only on the bit at position `RUN_BIT`. The other bits are stored and read back, and they have no effect here. The compare flag follows a two-step acknowledge: it can only be cleared by a status write after a status read has seen it set. A compare match that arrives in the same cycle as the clearing write wins. No bus transaction is ever stalled, so the bus needs no handshake. Writes take effect on the clock edge that samples them. Read data is a combinational function of the address.

Top module: `cmt_timer_chan`

## Requirements
- R1: After reset the control, mode, I/O-control, interrupt-enable, status, counter and start registers read 0, the compare register reads 0xFFFF and `irq` is low.
- R2: Registers decode at control 0x0, mode 0x1, I/O control 0x2, interrupt enable 0x4, status 0x5, counter 0x6, compare 0x8 and start 0xA. Counter and compare are 16 bits wide. All other registers are 8 bits wide: they take `bus_wdata[7:0]` and read back with the upper byte 0. Any other address reads 0.
- R3: The channel counts only while start register bit `RUN_BIT` is 1. The other start bits are stored and read back, and they have no effect on this channel.
- R4: Control bits [2:0] choose the count clock: 0 gives ÷1, 1 gives ÷4, 2 gives ÷16, and 3 through 7 give ÷64. The divider is held at zero while the run bit is 0, so the first increment lands on the N-th rising edge after the edge that sets the run bit.
- R5: When control bits [7:5] equal 1, a count tick that would bring the counter to the compare value C loads 0 instead, so the counter cycles through 0 to C−1. For any other value of bits [7:5], the counter increments freely and wraps from 0xFFFF to 0.
- R6: Status bit 0 (the compare flag) is set by every tick on which the incremented count equals the compare value, in either clear mode. Status bits [7:1] read 0.
- R7: A status write with bit 0 = 0 clears the flag only if a status read (`bus_rd` at 0x5) has seen the flag as 1 since the last status write. Any status write uses up that read. Writing 1 to bit 0 never sets the flag.
- R8: A compare match in the same cycle as a valid clearing write leaves the flag set.
- R9: `irq` equals the compare flag AND interrupt-enable bit 0. It is a level that stays high until the flag is cleared or the enable is dropped.
- R10: A write to the counter loads the written value, whether the channel is running or stopped. The write takes priority over a count tick in the same cycle.
- R11: While the channel is stopped, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the source of the count clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; only a status read uses it, to enable a later flag clear |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wdata | input | CNT_W (16) | Write data; 8-bit registers use bits [7:0] |
| bus_rdata | output | CNT_W (16) | Read data for `bus_addr` |
| irq | output | 1 | Compare-match interrupt, level |

## Verification
The hardest case to reach from the ports is a clearing write to the status register that lands on exactly the same edge as the next compare match, after a read that enabled the clear. The bench gets there with the ÷1 count clock and a compare value of 5, so matches fall on known edges. It counts falling edges from the start write, reads the status once the flag is up, and then times the 0xFE write to hit the next match edge. It then checks that the flag is still set, and that a fresh read followed by a write then clears it.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int REG_W  = 8;
  localparam int PRE_W  = 6;

  localparam int OFF_CTRL  = 0;
  localparam int OFF_MODE  = 1;
  localparam int OFF_IOC   = 2;
  localparam int OFF_IE    = 4;
  localparam int OFF_STAT  = 5;
  localparam int OFF_CNT   = 6;
  localparam int OFF_CMP   = 8;
  localparam int OFF_START = 10;

  localparam logic [2:0] CLR_ON_CMP = 3'd1;

  function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] code);
    case (code)
      3'd0:    div_limit = PRE_W'(0);
      3'd1:    div_limit = PRE_W'(3);
      3'd2:    div_limit = PRE_W'(15);
      default: div_limit = PRE_W'(63);
    endcase
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] lim;

  assign lim  = div_limit(code);
  assign tick = run && (div_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (!run || tick)  div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  // R4: a divided tick needs the run bit on in the cycle before
  p_div_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code != 3'd0) |-> $past(run));
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr_on_cmp,
  input  logic [W-1:0] cmp,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         match
);
  logic [W-1:0] nxt;

  assign nxt   = cnt + 1'b1;
  assign match = tick && (nxt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (tick) cnt <= (match && clr_on_cmp) ? '0 : nxt;
  end

  // R5: a clearing match returns the counter to zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && clr_on_cmp && !ld) |=> (cnt == '0));
  // R10: a load wins
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));
  // R11: no tick, no load, no change
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(cnt));
endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic st_rd,
  input  logic st_wr,
  input  logic wbit0,
  input  logic ie,
  output logic flag,
  output logic irq
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               armed <= 1'b0;
    else if (st_wr)           armed <= 1'b0;
    else if (st_rd && flag)   armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          flag <= 1'b0;
    else if (match)                      flag <= 1'b1;
    else if (st_wr && !wbit0 && armed)   flag <= 1'b0;
  end

  assign irq = flag & ie;

  // R6 and R8: a match always leaves the flag set
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);
  // R7: a flag that was not read as set cannot be cleared
  p_blind_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed) |=> flag);
endmodule

// File: rtl/cmt_timer_chan.sv
module cmt_timer_chan
  import cmt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 4,
  parameter int RUN_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [REG_W-1:0] ctrl_q, mode_q, ioc_q, ie_q, start_q;
  logic [CNT_W-1:0] cmp_q, cnt;
  logic             run, tick, match, flag, clr_mode;
  logic [REG_W-1:0] wbyte;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  assign wbyte    = bus_wdata[REG_W-1:0];
  assign run      = start_q[RUN_BIT];
  assign clr_mode = (ctrl_q[7:5] == CLR_ON_CMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mode_q  <= '0;
      ioc_q   <= '0;
      ie_q    <= '0;
      start_q <= '0;
      cmp_q   <= '1;
    end else if (bus_wr) begin
      if (at(bus_addr, OFF_CTRL))  ctrl_q  <= wbyte;
      if (at(bus_addr, OFF_MODE))  mode_q  <= wbyte;
      if (at(bus_addr, OFF_IOC))   ioc_q   <= wbyte;
      if (at(bus_addr, OFF_IE))    ie_q    <= wbyte;
      if (at(bus_addr, OFF_START)) start_q <= wbyte;
      if (at(bus_addr, OFF_CMP))   cmp_q   <= bus_wdata;
    end
  end

  cmt_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .code (ctrl_q[2:0]),
    .tick (tick)
  );

  cmt_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .clr_on_cmp(clr_mode),
    .cmp       (cmp_q),
    .ld        (bus_wr && at(bus_addr, OFF_CNT)),
    .ld_val    (bus_wdata),
    .cnt       (cnt),
    .match     (match)
  );

  cmt_flag u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .match(match),
    .st_rd(bus_rd && at(bus_addr, OFF_STAT)),
    .st_wr(bus_wr && at(bus_addr, OFF_STAT)),
    .wbit0(bus_wdata[0]),
    .ie   (ie_q[0]),
    .flag (flag),
    .irq  (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if      (at(bus_addr, OFF_CTRL))  bus_rdata = CNT_W'(ctrl_q);
    else if (at(bus_addr, OFF_MODE))  bus_rdata = CNT_W'(mode_q);
    else if (at(bus_addr, OFF_IOC))   bus_rdata = CNT_W'(ioc_q);
    else if (at(bus_addr, OFF_IE))    bus_rdata = CNT_W'(ie_q);
    else if (at(bus_addr, OFF_STAT))  bus_rdata = CNT_W'(flag);
    else if (at(bus_addr, OFF_CNT))   bus_rdata = cnt;
    else if (at(bus_addr, OFF_CMP))   bus_rdata = cmp_q;
    else if (at(bus_addr, OFF_START)) bus_rdata = CNT_W'(start_q);
  end

  // R7: the flag only falls after a status write
  p_fall_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> ($past(bus_wr) && $past(bus_addr) == ADDR_W'(OFF_STAT)));
  // R3: a stopped channel raises no match
  p_stopped_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !match);
endmodule

// File: tb/sim_cmt_timer_chan.sv
module sim_cmt_timer_chan;
  localparam int CLK_P = 10;
  localparam int RB    = 2;
  localparam logic [15:0] RUN = 16'(1 << RB);

  logic        clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic        irq;
  int n_chk = 0, n_bad = 0;

  cmt_timer_chan #(.CNT_W(16), .ADDR_W(4), .RUN_BIT(RB)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    bus_wr = 0; bus_rd = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    bus_rd = 1; bus_addr = a; #1 v = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] v);
    bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    foreach (v[i]) begin end
    peek(0, v);  chk("R1 ctrl", v, 0);
    peek(1, v);  chk("R1 mode", v, 0);
    peek(2, v);  chk("R1 ioc", v, 0);
    peek(4, v);  chk("R1 ie", v, 0);
    peek(5, v);  chk("R1 status", v, 0);
    peek(6, v);  chk("R1 cnt", v, 0);
    peek(8, v);  chk("R1 cmp", v, 16'hFFFF);
    peek(10, v); chk("R1 start", v, 0);
    chk("R1 irq", 16'(irq), 0);
  endtask

  task automatic t_regmap();
    logic [15:0] v;
    do_reset();
    wr(0, 16'h00A5); peek(0, v); chk("R2 ctrl", v, 16'h00A5);
    wr(1, 16'h003C); peek(1, v); chk("R2 mode", v, 16'h003C);
    wr(2, 16'h005A); peek(2, v); chk("R2 ioc", v, 16'h005A);
    wr(4, 16'h00FE); peek(4, v); chk("R2 ie", v, 16'h00FE);
    wr(8, 16'h1234); peek(8, v); chk("R2 cmp 16-bit", v, 16'h1234);
    wr(0, 16'hFF77); peek(0, v); chk("R2 upper byte dropped", v, 16'h0077);
    wr(6, 16'hBEEF); peek(6, v); chk("R10 cnt load stopped", v, 16'hBEEF);
    peek(3, v); chk("R2 hole 3", v, 0);
    peek(7, v); chk("R2 hole 7", v, 0);
  endtask

  task automatic t_start();
    logic [15:0] v;
    do_reset();
    wr(0, 16'h0020); wr(6, 16'h0010);
    wr(10, 16'h00FF ^ RUN);
    peek(10, v); chk("R3 other bits stored", v, 16'h00FF ^ RUN);
    repeat (5) @(negedge clk);
    peek(6, v); chk("R3 R11 other bits do not run", v, 16'h0010);
    wr(10, RUN);
    repeat (3) @(negedge clk);
    peek(6, v); chk("R3 run bit counts", v, 16'h0013);
    wr(10, 0);
    repeat (6) @(negedge clk);
    peek(6, v); chk("R11 hold when stopped", v, 16'h0014);
  endtask

  task automatic t_presc();
    logic [15:0] v;
    do_reset();
    wr(0, 16'h0023); wr(10, RUN);
    repeat (63) @(negedge clk);
    peek(6, v); chk("R4 div64 before", v, 0);
    @(negedge clk);
    peek(6, v); chk("R4 div64 first tick", v, 1);
    wr(10, 0); wr(0, 16'h0021); wr(6, 0); wr(10, RUN);
    repeat (3) @(negedge clk);
    peek(6, v); chk("R4 div4 before", v, 0);
    @(negedge clk);
    peek(6, v); chk("R4 div4 first tick", v, 1);
    repeat (4) @(negedge clk);
    peek(6, v); chk("R4 div4 second tick", v, 2);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    do_reset();
    wr(0, 16'h0020); wr(8, 5); wr(10, RUN);
    repeat (4) @(negedge clk);
    peek(6, v); chk("R5 cnt before match", v, 4);
    peek(5, v); chk("R6 flag before match", v, 0);
    @(negedge clk);
    peek(6, v); chk("R5 cnt wraps at cmp", v, 0);
    peek(5, v); chk("R6 flag on match", v, 1);
    repeat (4) @(negedge clk);
    peek(6, v); chk("R5 period top", v, 4);
    @(negedge clk);
    peek(6, v); chk("R5 period wrap", v, 0);
    do_reset();
    wr(0, 16'h0000); wr(8, 3); wr(6, 16'hFFFE); wr(10, RUN);
    repeat (2) @(negedge clk);
    peek(6, v); chk("R5 free wrap", v, 0);
    peek(5, v); chk("R6 no flag yet", v, 0);
    repeat (3) @(negedge clk);
    peek(6, v); chk("R5 free reaches cmp", v, 3);
    peek(5, v); chk("R6 flag free mode", v, 1);
    @(negedge clk);
    peek(6, v); chk("R5 free no clear", v, 4);
  endtask

  task automatic t_ack();
    logic [15:0] v;
    do_reset();
    wr(4, 1); wr(0, 16'h0020); wr(8, 2); wr(10, RUN);
    repeat (2) @(negedge clk);
    chk("R9 irq on flag", 16'(irq), 1);
    wr(10, 0);
    wr(4, 0); chk("R9 irq masked", 16'(irq), 0);
    wr(4, 1); chk("R9 irq level", 16'(irq), 1);
    wr(5, 16'h00FE);
    peek(5, v); chk("R7 clear without read ignored", v, 1);
    chk("R7 irq stays", 16'(irq), 1);
    rd(5, v); chk("R7 read sees flag", v, 1);
    wr(5, 16'h0001);
    peek(5, v); chk("R7 write one no effect", v, 1);
    wr(5, 16'h00FE);
    peek(5, v); chk("R7 stale read used up", v, 1);
    rd(5, v); wr(5, 16'h00FE);
    peek(5, v); chk("R7 read then clear", v, 0);
    chk("R9 irq falls", 16'(irq), 0);
  endtask

  task automatic t_race();
    logic [15:0] v;
    do_reset();
    wr(0, 16'h0020); wr(8, 5); wr(10, RUN);
    repeat (5) @(negedge clk);
    rd(5, v); chk("R8 flag seen", v, 1);
    repeat (3) @(negedge clk);
    wr(5, 16'h00FE);
    peek(5, v); chk("R8 match beats clear", v, 1);
    peek(6, v); chk("R8 cnt at match", v, 0);
    wr(10, 0);
    rd(5, v); wr(5, 16'h00FE);
    peek(5, v); chk("R8 later clear works", v, 0);
  endtask

  task automatic t_ldrun();
    logic [15:0] v;
    do_reset();
    wr(0, 0); wr(10, RUN);
    repeat (2) @(negedge clk);
    peek(6, v); chk("R10 running", v, 2);
    wr(6, 16'h0100);
    peek(6, v); chk("R10 load beats tick", v, 16'h0100);
    @(negedge clk);
    peek(6, v); chk("R10 counts on", v, 16'h0101);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_regmap();
    t_start();
    t_presc();
    t_clear();
    t_ack();
    t_race();
    t_ldrun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule